// File: doc/BRIEF.md
# Receive Byte Queue with Fill Threshold

This block is the receive-side holding queue between a serial bus engine and a register-mapped host. The engine pushes each received byte. The host reads a zero-based fill code and pops bytes one at a time through a data port. It also programs a zero-based threshold. While the queue holds more bytes than that threshold, a level output stays high. A one-cycle pulse marks each rising edge of the level, so that an interrupt collector can latch it.

Fill tracking is a three-state machine. The states are Q_EMPTY (no bytes), Q_PARTIAL (between one and DEPTH-1 bytes) and Q_FULL (DEPTH bytes). The transitions are: EMPTY_TO_PARTIAL on an accepted push; PARTIAL_TO_FULL when an accepted push brings the count to DEPTH; PARTIAL_TO_EMPTY when an accepted pop takes the last byte; FULL_TO_PARTIAL on an accepted pop. A push and a pop in the same cycle in Q_PARTIAL leave the state unchanged. The empty and full flags are decoded from the state.

Between bursts the host can lower or raise the threshold, so that the next indication covers only the bytes it still expects. A synchronous reset empties the queue and returns the threshold to its maximum.

Top module: `rx_byte_queue`

## Requirements
- R1: In the cycle after `srst` is sampled high, the outputs read as follows: `empty`=1, `full`=0, `occ_code`=0, `thr_value`=15, `thr_level`=0, `thr_pulse`=0, `overflow`=0 and `pop_data`=0.
- R2: A byte pushed while the queue is not full is stored. Bytes come out in the order they were pushed. An accepted pop loads the oldest byte into `pop_data` on that same clock edge.
- R3: `occ_code` reads the stored byte count minus one while the queue is not empty, and 0 when it is empty. `empty` is 1 exactly when no byte is stored.
- R4: `full` is 1 exactly when 16 bytes are stored.
- R5: A push in a cycle that starts with the queue full is dropped, even if a pop is accepted in the same cycle. The dropped push sets `overflow`, which stays at 1 until reset.
- R6: A pop in a cycle that starts with the queue empty leaves `pop_data` unchanged and does not move the read position. A push in that same cycle is still accepted.
- R7: A push and a pop in the same cycle on a partly filled queue are both performed, and the count does not change.
- R8: The threshold code `thr_value` is zero-based. `thr_level` is 1 while the stored count is at least `thr_value`+1.
- R9: `thr_pulse` is 1 for exactly the first cycle in which `thr_level` is 1 after a cycle in which it was 0. This holds whether the rise comes from a push or from a threshold write.
- R10: A write with `thr_we`=1 makes `thr_value` equal to `thr_wdata` from the next cycle, and the level comparison uses the new value from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| push_req | input | 1 | Byte strobe from the bus engine |
| push_data | input | 8 | Received byte |
| pop_req | input | 1 | Host read of the data port |
| pop_data | output | 8 | Last byte popped |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 4 | New zero-based threshold |
| thr_value | output | 4 | Current threshold |
| occ_code | output | 4 | Stored count minus one (0 when empty) |
| empty | output | 1 | No byte stored |
| full | output | 1 | 16 bytes stored |
| thr_level | output | 1 | Count is at or above threshold+1 |
| thr_pulse | output | 1 | One-cycle rising-edge marker of thr_level |
| overflow | output | 1 | Sticky flag for a dropped push |

## Verification
The assertions assume that `srst` is held high for the first clock edges, so that no property looks back at power-up values. They also assume that the strobes are valid 0/1 levels in every cycle. The bench meets both assumptions: it drives every input at the falling edge from a single task, and it starts with two reset cycles. The bench deliberately combines the strobes, for example a push onto a full queue, a pop from an empty one, and a threshold write in the same cycle as a push. This way the ignore and drop rules are exercised both alone and in combination.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } fill_state_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    localparam int PW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= wr_ptr + PW'(1);
            end
            if (rd_en) begin
                rd_ptr  <= rd_ptr + PW'(1);
                rd_data <= mem[rd_ptr];
            end
        end
    end

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (srst)
        !rd_en |=> $stable(rd_data)); // R6
    AST_PTR_IDLE: assert property (@(posedge clk) disable iff (srst)
        !wr_en && !rd_en |=> $stable(wr_ptr) && $stable(rd_ptr)); // R6
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          wr_en,
    output logic          rd_en,
    output fill_state_t   state,
    output logic [CW-1:0] count,
    output logic          ovf
);
    fill_state_t   state_nxt;
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        wr_en   = push_req && (state != Q_FULL);
        rd_en   = pop_req && (state != Q_EMPTY);
        cnt_nxt = count + CW'(wr_en) - CW'(rd_en);
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            Q_EMPTY: begin
                if (wr_en) begin
                    state_nxt = (cnt_nxt == CW'(DEPTH)) ? Q_FULL : Q_PARTIAL;
                end
            end
            Q_PARTIAL: begin
                if (cnt_nxt == '0) begin
                    state_nxt = Q_EMPTY;
                end else if (cnt_nxt == CW'(DEPTH)) begin
                    state_nxt = Q_FULL;
                end
            end
            Q_FULL: begin
                if (rd_en) begin
                    state_nxt = (cnt_nxt == '0) ? Q_EMPTY : Q_PARTIAL;
                end
            end
            default: state_nxt = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            state <= Q_EMPTY;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            state <= state_nxt;
            count <= cnt_nxt;
            if (push_req && (state == Q_FULL)) begin
                ovf <= 1'b1;
            end
        end
    end

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (srst)
        (state == Q_EMPTY) == (count == '0)); // R3
    AST_FULL_DEPTH: assert property (@(posedge clk) disable iff (srst)
        (state == Q_FULL) == (count == CW'(DEPTH))); // R4
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (srst)
        push_req && !pop_req && (state == Q_FULL) |=> (count == $past(count)) && ovf); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (srst)
        ovf |=> ovf); // R5
    AST_PAIR_KEEP: assert property (@(posedge clk) disable iff (srst)
        push_req && pop_req && (state == Q_PARTIAL) |=> count == $past(count)); // R7
endmodule

// File: rtl/rxq_mark.sv
module rxq_mark #(
    parameter int PW    = 4,
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          srst,
    input  logic [CW-1:0] count,
    input  logic          thr_we,
    input  logic [PW-1:0] thr_wdata,
    output logic [PW-1:0] thr_value,
    output logic          level,
    output logic          pulse
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (srst) begin
            thr_value <= '1;
            level_q   <= 1'b0;
        end else begin
            if (thr_we) begin
                thr_value <= thr_wdata;
            end
            level_q <= level;
        end
    end

    always_comb begin
        level = count > {1'b0, thr_value};
        pulse = level && !level_q;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (srst)
        pulse |=> !pulse); // R9
    AST_PULSE_LEVEL: assert property (@(posedge clk) disable iff (srst)
        pulse |-> level); // R9
    AST_THR_WRITE: assert property (@(posedge clk) disable iff (srst)
        thr_we |=> thr_value == $past(thr_wdata)); // R10
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    output logic [DW-1:0] pop_data,
    input  logic          thr_we,
    input  logic [PW-1:0] thr_wdata,
    output logic [PW-1:0] thr_value,
    output logic [PW-1:0] occ_code,
    output logic          empty,
    output logic          full,
    output logic          thr_level,
    output logic          thr_pulse,
    output logic          overflow
);
    fill_state_t   state;
    logic [CW-1:0] count;
    logic          wr_en;
    logic          rd_en;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .srst     (srst),
        .push_req (push_req),
        .pop_req  (pop_req),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .state    (state),
        .count    (count),
        .ovf      (overflow)
    );

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .srst    (srst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_data (push_data),
        .rd_data (pop_data)
    );

    rxq_mark #(.PW(PW)) u_mark (
        .clk       (clk),
        .srst      (srst),
        .count     (count),
        .thr_we    (thr_we),
        .thr_wdata (thr_wdata),
        .thr_value (thr_value),
        .level     (thr_level),
        .pulse     (thr_pulse)
    );

    always_comb begin
        empty    = (state == Q_EMPTY);
        full     = (state == Q_FULL);
        occ_code = (count == '0) ? '0 : PW'(count - CW'(1));
    end

    AST_POP_EMPTY_HOLD: assert property (@(posedge clk) disable iff (srst)
        pop_req && empty |=> $stable(pop_data)); // R6
    AST_FLAGS_APART: assert property (@(posedge clk) disable iff (srst)
        !(empty && full)); // R3
endmodule

// File: tb/test_rx_byte_queue.sv
module test_rx_byte_queue;
    logic       clk = 1'b0;
    logic       srst = 1'b1;
    logic       push_req = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop_req = 1'b0;
    logic [7:0] pop_data;
    logic       thr_we = 1'b0;
    logic [3:0] thr_wdata = '0;
    logic [3:0] thr_value;
    logic [3:0] occ_code;
    logic       empty, full, thr_level, thr_pulse, overflow;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    rx_byte_queue i_rx_byte_queue (
        .clk(clk), .srst(srst), .push_req(push_req), .push_data(push_data),
        .pop_req(pop_req), .pop_data(pop_data), .thr_we(thr_we),
        .thr_wdata(thr_wdata), .thr_value(thr_value), .occ_code(occ_code),
        .empty(empty), .full(full), .thr_level(thr_level),
        .thr_pulse(thr_pulse), .overflow(overflow)
    );

    // behavioural reference
    byte unsigned q[$];
    int  m_thr   = 15;
    int  m_data  = 0;
    bit  m_ovf   = 0;
    bit  m_pulse = 0;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(bit r, bit p, int d, bit rd, bit we, int w);
        bit old_lvl, new_lvl, was_full, was_empty;
        srst = r; push_req = p; push_data = 8'(d);
        pop_req = rd; thr_we = we; thr_wdata = 4'(w);
        @(posedge clk);
        if (r) begin
            q.delete(); m_thr = 15; m_data = 0; m_ovf = 0; m_pulse = 0;
        end else begin
            old_lvl   = q.size() > m_thr;
            was_full  = q.size() == 16;
            was_empty = q.size() == 0;
            if (rd && !was_empty) m_data = q.pop_front();
            if (p) begin
                if (was_full) m_ovf = 1;
                else q.push_back(byte'(d));
            end
            if (we) m_thr = w;
            new_lvl = q.size() > m_thr;
            m_pulse = new_lvl && !old_lvl;
        end
        @(negedge clk);
        chk("R3 occ_code", occ_code, q.size() == 0 ? 0 : q.size() - 1);
        chk("R3 empty", empty, q.size() == 0);
        chk("R4 full", full, q.size() == 16);
        chk("R2 pop_data", pop_data, m_data);
        chk("R5 overflow", overflow, m_ovf);
        chk("R10 thr_value", thr_value, m_thr);
        chk("R8 thr_level", thr_level, q.size() > m_thr);
        chk("R9 thr_pulse", thr_pulse, m_pulse);
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        // R1 reset state
        cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        // R2 R3 ordered push and drain
        for (int i = 0; i < 3; i++) cyc(0, 1, 8'h30 + i, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 0);
        // R6 pop on empty, with and without push
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 1, 8'h77, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        // R4 R5 fill to capacity and overflow
        for (int i = 0; i < 17; i++) cyc(0, 1, 8'h80 + i, 0, 0, 0);
        cyc(0, 1, 8'hEE, 1, 0, 0);           // R5 push dropped with pop
        cyc(0, 1, 8'hEF, 1, 0, 0);           // R7 pair on partial
        for (int i = 0; i < 17; i++) cyc(0, 0, 0, 1, 0, 0);
        // R8 R9 threshold 3: level at 4 bytes
        cyc(0, 0, 0, 0, 1, 3);
        for (int i = 0; i < 5; i++) cyc(0, 1, 8'h10 + i, 0, 0, 0);
        // R10 raise then lower threshold, rise from write
        cyc(0, 0, 0, 0, 1, 9);
        cyc(0, 0, 0, 0, 1, 1);
        cyc(0, 1, 8'h55, 0, 1, 15);          // write with push
        cyc(1, 0, 0, 0, 0, 0);               // R1 reset mid-run
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[11:0] == 12'h0, lfsr[0] | lfsr[5], lfsr[15:8],
                lfsr[1] & lfsr[3], lfsr[2] & lfsr[4] & lfsr[6], lfsr[12:9]);
        end
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule